// File: doc/BRIEF.md
# Serial-Access Control Register Bank

This block lets an external host reach a bank of 128 eight-bit control registers over a four-wire serial link. The link has a select line (active low), a serial clock, a host-to-target data line and a target-to-host data line. Each access is a 16-bit frame. A write frame stores a byte in one register. A read frame returns the contents of one register on the output line.

The serial inputs are not used as clocks. All three pass through two-flop synchronizers into the system clock domain. The block then finds the serial clock edges by comparing successive samples. Core logic on the chip has its own parallel port. It can read any register and update any register through that port while the serial side is active.

The serial output idles high. During a read it presents the register byte on the falling edges after the address. Once the byte has been sent, the output holds the last bit until the host releases select.

Top module: `spi_regbank`

## Requirements
- R1: A frame is 16 bits sent MSB first. Bit 15 is the direction bit, bits 14..8 are the register address (most significant address bit first) and bits 7..0 are the data byte (most significant bit first). Input bits are taken on rising serial clock edges.
- R2: When the direction bit is 1, the data byte is stored in the addressed register on the 16th rising serial clock edge.
- R3: When the direction bit is 0, the data byte sent by the host is ignored and the addressed register keeps its value.
- R4: In a read frame, the addressed register is driven on the output over the eight falling serial clock edges that follow the 8th rising edge, MSB first. The bit driven after the falling edge that follows rising edge 8+k is register bit 7-k.
- R5: After the last read bit has been driven, the output holds that bit until select goes high, even if more clock edges arrive.
- R6: While select is high, the output is 1. During a write frame the output stays 1.
- R7: If select rises before the 16th rising edge, no register changes. The next frame starts again at bit 15.
- R8: After the 16th rising edge, further serial clock edges in the same frame have no effect on any register.
- R9: After reset, every register reads 0 and the output is 1.
- R10: When the host write enable is high at a system clock edge, the host port stores its data byte in the host write address. Host read data shows the register at the host read address one system clock after the address is presented.
- R11: A serial rising edge takes effect at the third rising system clock edge after it. If a serial write and a host write target the same register at that edge, the serial data is stored.
- R12: Frames are handled correctly with a serial clock half-period of two system clocks (system clock at 4x the serial clock rate). The output changes three system clocks after a falling serial edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| host_rd_addr | input | 7 | Core-side read address |
| host_rd_data | output | 8 | Core-side read data, registered |
| host_wr_en | input | 1 | Core-side write enable |
| host_wr_addr | input | 7 | Core-side write address |
| host_wr_data | input | 8 | Core-side write data |

## Verification
Errors in the bit counter show up in two ways. A frame can land in the wrong register, which a read of both neighbours exposes. A frame can also fail to end, in which case a long frame writes again after the 16th bit. Both effects are visible within one frame. A wrong transmit shift state corrupts the byte read back within eight serial clocks. If the output is not held or not returned high, a sample taken after the last bit, or after deselect, differs from the expected level. A broken write priority leaves the host byte in place of the serial byte, and this can be seen on the next host read, one system clock later.

// File: rtl/spi_regbank_pkg.sv
package spi_regbank_pkg;
  localparam int unsigned REG_ADDR_W = 7;
  localparam int unsigned REG_DATA_W = 8;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/spi_regbank_sync.sv
module spi_regbank_sync #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_regbank_frame.sv
module spi_regbank_frame #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n_s,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] reg_addr,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          miso
);
  localparam int unsigned HDR   = 1 + AW;
  localparam int unsigned FRAME = HDR + DW;
  localparam int unsigned CW    = $clog2(FRAME + 1);
  localparam int unsigned SHW   = (AW > DW - 1) ? AW : DW - 1;
  localparam logic [CW-1:0] C_HDR_LAST = CW'(HDR - 1);
  localparam logic [CW-1:0] C_HDR      = CW'(HDR);
  localparam logic [CW-1:0] C_LAST     = CW'(FRAME - 1);
  localparam logic [CW-1:0] C_END      = CW'(FRAME);

  logic          sck_d;
  logic          rise, fall, active, take;
  logic [CW-1:0] cnt;
  logic [SHW-1:0] sh;
  logic          rw_q;
  logic [DW-1:0] tx;

  assign rise   = sck_s & ~sck_d;
  assign fall   = ~sck_s & sck_d;
  assign active = ~cs_n_s;
  assign take   = active & rise & (cnt != C_END);

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  // bit counter: cleared on deselect, saturates at end of frame
  always_ff @(posedge clk) begin
    if (rst || cs_n_s) cnt <= '0;
    else if (take)     cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       sh <= '0;
    else if (take) sh <= {sh[SHW-2:0], mosi_s};
  end

  // header capture after the first byte
  always_ff @(posedge clk) begin
    if (rst) begin
      rw_q     <= 1'b0;
      reg_addr <= '0;
    end else if (take && cnt == C_HDR_LAST) begin
      rw_q     <= sh[AW-1];
      reg_addr <= {sh[AW-2:0], mosi_s};
    end
  end

  assign wr_en   = take && (cnt == C_LAST) && rw_q;
  assign wr_data = {sh[DW-2:0], mosi_s};

  // serial output: idles high, shifts on falling edges of the data phase
  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      miso <= 1'b1;
      tx   <= '0;
    end else if (fall && !rw_q && cnt >= C_HDR && cnt < C_END) begin
      if (cnt == C_HDR) begin
        miso <= rd_data[DW-1];
        tx   <= {rd_data[DW-2:0], 1'b0};
      end else begin
        miso <= tx[DW-1];
        tx   <= {tx[DW-2:0], 1'b0};
      end
    end
  end

  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst) cnt <= C_END); // R8
  AST_WR_ENDS_FRAME: assert property (@(posedge clk) disable iff (rst) wr_en |=> cnt == C_END); // R2
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst) cs_n_s |=> miso); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst) (active && !fall) |=> $stable(miso)); // R5
endmodule

// File: rtl/spi_regbank_array.sv
module spi_regbank_array #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_we,
  input  logic [AW-1:0] spi_addr,
  input  logic [DW-1:0] spi_wdata,
  output logic [DW-1:0] spi_rdata,
  input  logic          host_we,
  input  logic [AW-1:0] host_waddr,
  input  logic [DW-1:0] host_wdata,
  input  logic [AW-1:0] host_raddr,
  output logic [DW-1:0] host_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // later assignment wins: serial write overrides host write on a clash
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (host_we) mem[host_waddr] <= host_wdata;
      if (spi_we)  mem[spi_addr]   <= spi_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spi_rdata  <= '0;
      host_rdata <= '0;
    end else begin
      spi_rdata  <= mem[spi_addr];
      host_rdata <= mem[host_raddr];
    end
  end

  AST_SPI_WINS: assert property (@(posedge clk) disable iff (rst)
    (spi_we && host_we && spi_addr == host_waddr) |=> mem[$past(spi_addr)] == $past(spi_wdata)); // R11
  AST_HOST_STORE: assert property (@(posedge clk) disable iff (rst)
    (host_we && !(spi_we && spi_addr == host_waddr)) |=> mem[$past(host_waddr)] == $past(host_wdata)); // R10
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank
  import spi_regbank_pkg::*;
#(
  parameter int unsigned AW = REG_ADDR_W,
  parameter int unsigned DW = REG_DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_cs_n,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [AW-1:0] host_rd_addr,
  output logic [DW-1:0] host_rd_data,
  input  logic          host_wr_en,
  input  logic [AW-1:0] host_wr_addr,
  input  logic [DW-1:0] host_wr_data
);
  logic          cs_n_s, sck_s, mosi_s;
  logic [AW-1:0] reg_addr;
  logic          wr_en;
  logic [DW-1:0] wr_data, rd_data;

  spi_regbank_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sck, spi_mosi}),
    .q   ({cs_n_s, sck_s, mosi_s})
  );

  spi_regbank_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk      (clk),
    .rst      (rst),
    .cs_n_s   (cs_n_s),
    .sck_s    (sck_s),
    .mosi_s   (mosi_s),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .miso     (spi_miso)
  );

  spi_regbank_array #(.AW(AW), .DW(DW)) u_array (
    .clk        (clk),
    .rst        (rst),
    .spi_we     (wr_en),
    .spi_addr   (reg_addr),
    .spi_wdata  (wr_data),
    .spi_rdata  (rd_data),
    .host_we    (host_wr_en),
    .host_waddr (host_wr_addr),
    .host_wdata (host_wr_data),
    .host_raddr (host_rd_addr),
    .host_rdata (host_rd_data)
  );
endmodule

// File: tb/spi_regbank_tb.sv
module spi_regbank_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic       miso;
  logic [6:0] host_rd_addr = '0, host_wr_addr = '0;
  logic [7:0] host_rd_data, host_wr_data = '0;
  logic       host_wr_en = 1'b0;

  spi_regbank u_dut (
    .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .host_rd_addr(host_rd_addr), .host_rd_data(host_rd_data),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  string      tag_q[$];
  event       rd_ev;
  int         coll_ofs = 0;
  logic [6:0] coll_addr = '0;
  logic [7:0] coll_data = '0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(rd_ev);
      while (got_q.size() > 0 && exp_q.size() > 0)
        check(tag_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  task automatic spi_frame(input bit rw, input logic [6:0] a, input logic [7:0] d,
                           input int nbits, input int half, output logic [7:0] cap);
    logic [15:0] frm;
    frm = {rw, a, d};
    cap = '0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (half) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? frm[15-i] : 1'b1;
      repeat (half) @(negedge clk);
      sck = 1'b1;
      if (i == 15 && coll_ofs > 0) begin
        fork
          begin
            repeat (coll_ofs) @(negedge clk);
            host_wr_addr = coll_addr;
            host_wr_data = coll_data;
            host_wr_en   = 1'b1;
            @(negedge clk);
            host_wr_en   = 1'b0;
          end
        join_none
      end
      repeat (half) @(negedge clk);
      if (i >= 8 && i < 16) cap = {cap[6:0], miso};
      sck = 1'b0;
    end
    repeat (half + 4) @(negedge clk);
  endtask

  task automatic spi_end();
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 idle high", {7'b0, miso}, 8'h01);
  endtask

  task automatic spi_write(input logic [6:0] a, input logic [7:0] d, input int nbits, input int half);
    logic [7:0] c;
    spi_frame(1'b1, a, d, nbits, half, c);
    check("R6 high during write", {7'b0, miso}, 8'h01);
    spi_end();
  endtask

  task automatic spi_read(input logic [6:0] a, input logic [7:0] junk, input logic [7:0] exp,
                          input int nbits, input int half, input string tag);
    logic [7:0] c;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    spi_frame(1'b0, a, junk, nbits, half, c);
    got_q.push_back(c);
    ->rd_ev;
    repeat (6) @(negedge clk);
    check("R5 hold last bit", {7'b0, miso}, {7'b0, exp[0]});
    spi_end();
  endtask

  task automatic host_read(input logic [6:0] a, output logic [7:0] v);
    @(negedge clk);
    host_rd_addr = a;
    @(negedge clk);
    v = host_rd_data;
  endtask

  task automatic host_write(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr_addr = a;
    host_wr_data = d;
    host_wr_en   = 1'b1;
    @(negedge clk);
    host_wr_en   = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R9 reset state
    check("R9 output after reset", {7'b0, miso}, 8'h01);
    host_read(7'd0, v);   check("R9 reg 0", v, 8'h00);
    host_read(7'd127, v); check("R9 reg 127", v, 8'h00);
    host_read(7'd64, v);  check("R9 reg 64", v, 8'h00);
    spi_read(7'd0, 8'h00, 8'h00, 16, 8, "R9 serial read after reset");

    // R1 R2 writes, read back both ways (R4)
    spi_write(7'd0, 8'hA5, 16, 8);
    spi_write(7'd127, 8'h3C, 16, 8);
    spi_write(7'h55, 8'hFF, 16, 8);
    spi_write(7'h2A, 8'h01, 16, 8);
    host_read(7'd0, v);   check("R2 reg 0", v, 8'hA5);
    host_read(7'd127, v); check("R2 reg 127", v, 8'h3C);
    host_read(7'h55, v);  check("R1 reg 55", v, 8'hFF);
    host_read(7'h2A, v);  check("R1 reg 2A", v, 8'h01);
    host_read(7'd1, v);   check("R1 neighbour 1 untouched", v, 8'h00);
    spi_read(7'd0, 8'h00, 8'hA5, 16, 8, "R4 read reg 0");
    spi_read(7'd127, 8'h00, 8'h3C, 16, 8, "R4 read reg 127");
    spi_read(7'h2A, 8'h00, 8'h01, 16, 8, "R4 read reg 2A");

    // R3 data bits of a read ignored
    spi_read(7'h55, 8'h00, 8'hFF, 16, 8, "R3 read with zero data");
    spi_read(7'h2A, 8'hFF, 8'h01, 16, 8, "R3 read with ones data");
    host_read(7'h55, v); check("R3 reg 55 kept", v, 8'hFF);
    host_read(7'h2A, v); check("R3 reg 2A kept", v, 8'h01);

    // R7 aborted writes
    spi_write(7'h10, 8'h99, 12, 8);
    spi_write(7'h10, 8'h99, 15, 8);
    host_read(7'h10, v); check("R7 aborted write no effect", v, 8'h00);
    spi_write(7'h10, 8'h42, 16, 8);
    spi_read(7'h10, 8'h00, 8'h42, 16, 8, "R7 frame after abort");

    // R8 extra clocks ignored
    spi_write(7'h20, 8'h5A, 32, 4);
    host_read(7'h20, v);  check("R8 reg 20 after long frame", v, 8'h5A);
    host_read(7'd127, v); check("R8 no second write", v, 8'h3C);
    spi_read(7'h20, 8'h00, 8'h5A, 26, 4, "R8 read with extra clocks");

    // R10 host port
    host_write(7'h33, 8'hC3);
    host_read(7'h33, v); check("R10 host write/read", v, 8'hC3);
    spi_read(7'h33, 8'h00, 8'hC3, 16, 8, "R10 serial sees host write");

    // R11 clash at the serial write edge
    coll_addr = 7'd9;
    coll_data = 8'h11;
    coll_ofs  = 2;
    spi_write(7'd9, 8'h77, 16, 8);
    coll_ofs  = 0;
    host_read(7'd9, v); check("R11 serial wins clash", v, 8'h77);
    coll_ofs  = 3;
    spi_write(7'd9, 8'h78, 16, 8);
    coll_ofs  = 0;
    host_read(7'd9, v); check("R11 host write one cycle later", v, 8'h11);

    // R12 fastest serial clock
    spi_write(7'h44, 8'h96, 16, 2);
    spi_read(7'h44, 8'h5A, 8'h96, 16, 2, "R12 fast read");
    spi_write(7'h45, 8'h69, 16, 2);
    host_read(7'h45, v); check("R12 fast write", v, 8'h69);

    repeat (10) @(negedge clk);
    check("R4 scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule